// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits beside a two-port 4K-word memory and turns accesses to two fixed words into interrupts between the ports. The word at 0xFFE is the left port's inbox and the word at 0xFFF is the right port's inbox. When the right port writes 0xFFE, the left interrupt goes active. When the left port writes 0xFFF, the right interrupt goes active. Each side acknowledges by reading its own inbox. The 16-bit message at either address is ordinary memory content. It is stored and read by the memory array, which lies outside this block. This block only watches the control and address lines of both ports.

Both ports present active-low select, write strobe and output enable, plus a 12-bit address. Each interrupt output is active low and is driven from a register. A function-enable input turns the mechanism off, and the two top words then behave as plain memory.

Top module: `mailbox_irq`

## Requirements
- R1: While `rst` is high, and on the first sampled edge after it, both `l_irq_n` and `r_irq_n` are 1. This holds even if a mailbox write is presented during reset.
- R2: A right-port write (`r_sel_n`=0, `r_we_n`=0) to address 0xFFE with `func_en`=1 drives `l_irq_n` to 0 at the next rising clock edge.
- R3: A left-port write (`l_sel_n`=0, `l_we_n`=0) to address 0xFFF with `func_en`=1 drives `r_irq_n` to 0 at the next rising clock edge.
- R4: A left-port read (`l_sel_n`=0, `l_oe_n`=0) of 0xFFE returns `l_irq_n` to 1 at the next edge, unless R8 applies. The value of `l_we_n` does not matter for this read.
- R5: A right-port read (`r_sel_n`=0, `r_oe_n`=0) of 0xFFF returns `r_irq_n` to 1 at the next edge, unless R8 applies. The value of `r_we_n` does not matter for this read.
- R6: A write counts only when select and write strobe are both 0; the output enable is ignored for it. A strobe without select sets nothing.
- R7: Writes to any other address, including a port's own inbox, leave both interrupt outputs unchanged.
- R8: When a setting write and a clearing read target the same inbox in the same cycle, the interrupt becomes or stays 0.
- R9: With `func_en`=0 both outputs are 1 from the next edge on. Any pending interrupt is dropped, and mailbox accesses made while disabled leave no effect after re-enabling.
- R10: With no setting write and no clearing read, each interrupt output keeps its value.
- R11: Reads of addresses other than a port's own inbox do not clear that port's interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| func_en | input | 1 | 1 enables mailbox interrupts, 0 makes the top words plain memory |
| l_sel_n | input | 1 | Left port select, active low |
| l_we_n | input | 1 | Left port write strobe, active low |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | 12 | Left port word address |
| r_sel_n | input | 1 | Right port select, active low |
| r_we_n | input | 1 | Right port write strobe, active low |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | 12 | Right port word address |
| l_irq_n | output | 1 | Interrupt to the left port, active low, registered |
| r_irq_n | output | 1 | Interrupt to the right port, active low, registered |

## Verification
The properties assume that every control and address input is stable and known at each rising edge. In other words, the two ports are synchronous to `clk`, and no metastable or undriven lines reach the decoders. The bench respects this by changing inputs only on the falling edge and always driving full, defined values. Idle cycles hold select high, and the address stays defined even while a port is deselected. The bench also covers the ambiguous cases deliberately: a write with the output enable active, and a read with the write strobe active. This confirms that the checker's read and write qualifications match the requirement wording and not only the common case.

// File: rtl/mailbox_irq_pkg.sv
package mailbox_irq_pkg;

  // Decoded, active-high view of one port's control pins.
  typedef struct packed {
    logic sel;
    logic we;
    logic oe;
  } port_ctl_t;

  function automatic port_ctl_t ctl_from_pins(input logic sel_n,
                                              input logic we_n,
                                              input logic oe_n);
    port_ctl_t c;
    c.sel = ~sel_n;
    c.we  = ~we_n;
    c.oe  = ~oe_n;
    return c;
  endfunction

  // A write needs select and strobe; output enable is irrelevant.
  function automatic logic is_write(input port_ctl_t c);
    return c.sel & c.we;
  endfunction

  // A clearing read needs select and output enable; strobe is irrelevant.
  function automatic logic is_read(input port_ctl_t c);
    return c.sel & c.oe;
  endfunction

endpackage

// File: rtl/mailbox_port_decode.sv
module mailbox_port_decode
  import mailbox_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '1
) (
  input  logic              sel_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              set_peer,
  output logic              clr_own
);

  port_ctl_t ctl;

  always_comb begin
    ctl      = ctl_from_pins(sel_n, we_n, oe_n);
    set_peer = is_write(ctl) && (addr == PEER_BOX);
    clr_own  = is_read(ctl)  && (addr == OWN_BOX);
  end

endmodule

// File: rtl/mailbox_irq_flag.sv
module mailbox_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic func_en,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);

  // Set wins over clear; disable forces the inactive level.
  always_ff @(posedge clk) begin
    if (rst || !func_en) begin
      irq_n <= 1'b1;
    end else if (set_req) begin
      irq_n <= 1'b0;
    end else if (clr_req) begin
      irq_n <= 1'b1;
    end
  end

endmodule

// File: rtl/mailbox_irq.sv
module mailbox_irq #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              func_en,
  input  logic              l_sel_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_sel_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);

  localparam int unsigned NPORT = 2;
  localparam logic [ADDR_W-1:0] TOP_WORD = '1;
  localparam logic [ADDR_W-1:0] L_BOX    = TOP_WORD - 1'b1;
  localparam logic [ADDR_W-1:0] R_BOX    = TOP_WORD;

  // Index 0 is the left port, index 1 is the right port.
  logic              sel_n_v [NPORT];
  logic              we_n_v  [NPORT];
  logic              oe_n_v  [NPORT];
  logic [ADDR_W-1:0] addr_v  [NPORT];
  logic              set_v   [NPORT];
  logic              clr_v   [NPORT];
  logic              irq_v   [NPORT];

  always_comb begin
    sel_n_v[0] = l_sel_n;  sel_n_v[1] = r_sel_n;
    we_n_v[0]  = l_we_n;   we_n_v[1]  = r_we_n;
    oe_n_v[0]  = l_oe_n;   oe_n_v[1]  = r_oe_n;
    addr_v[0]  = l_addr;   addr_v[1]  = r_addr;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? L_BOX : R_BOX;
    localparam logic [ADDR_W-1:0] PEER = (p == 0) ? R_BOX : L_BOX;

    mailbox_port_decode #(
      .ADDR_W   (ADDR_W),
      .PEER_BOX (PEER),
      .OWN_BOX  (OWN)
    ) u_dec (
      .sel_n    (sel_n_v[p]),
      .we_n     (we_n_v[p]),
      .oe_n     (oe_n_v[p]),
      .addr     (addr_v[p]),
      .set_peer (set_v[p]),
      .clr_own  (clr_v[p])
    );

    // A port's flag is set by the opposite port's write.
    mailbox_irq_flag u_flag (
      .clk     (clk),
      .rst     (rst),
      .func_en (func_en),
      .set_req (set_v[NPORT-1-p]),
      .clr_req (clr_v[p]),
      .irq_n   (irq_v[p])
    );
  end

  assign l_irq_n = irq_v[0];
  assign r_irq_n = irq_v[1];

endmodule

// File: rtl/mailbox_irq_chk.sv
module mailbox_irq_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              func_en,
  input logic              l_sel_n,
  input logic              l_we_n,
  input logic              l_oe_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_sel_n,
  input logic              r_we_n,
  input logic              r_oe_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_irq_n,
  input logic              r_irq_n
);

  localparam logic [ADDR_W-1:0] HI_W  = '1;
  localparam logic [ADDR_W-1:0] LBOX  = HI_W - 1'b1;
  localparam logic [ADDR_W-1:0] RBOX  = HI_W;

  logic raise_l, raise_r, ack_l, ack_r;
  assign raise_l = !r_sel_n && !r_we_n && (r_addr == LBOX);
  assign raise_r = !l_sel_n && !l_we_n && (l_addr == RBOX);
  assign ack_l   = !l_sel_n && !l_oe_n && (l_addr == LBOX);
  assign ack_r   = !r_sel_n && !r_oe_n && (r_addr == RBOX);

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (l_irq_n && r_irq_n));

  p_raise_left_r2: assert property (@(posedge clk) disable iff (rst)
    (func_en && raise_l) |=> !l_irq_n);

  p_raise_right_r3: assert property (@(posedge clk) disable iff (rst)
    (func_en && raise_r) |=> !r_irq_n);

  p_ack_left_r4: assert property (@(posedge clk) disable iff (rst)
    (func_en && ack_l && !raise_l) |=> l_irq_n);

  p_ack_right_r5: assert property (@(posedge clk) disable iff (rst)
    (func_en && ack_r && !raise_r) |=> r_irq_n);

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !func_en |=> (l_irq_n && r_irq_n));

  p_hold_left_r10: assert property (@(posedge clk) disable iff (rst)
    (func_en && !raise_l && !ack_l) |=> $stable(l_irq_n));

  p_hold_right_r10: assert property (@(posedge clk) disable iff (rst)
    (func_en && !raise_r && !ack_r) |=> $stable(r_irq_n));

endmodule

bind mailbox_irq mailbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .func_en (func_en),
  .l_sel_n (l_sel_n),
  .l_we_n  (l_we_n),
  .l_oe_n  (l_oe_n),
  .l_addr  (l_addr),
  .r_sel_n (r_sel_n),
  .r_we_n  (r_we_n),
  .r_oe_n  (r_oe_n),
  .r_addr  (r_addr),
  .l_irq_n (l_irq_n),
  .r_irq_n (r_irq_n)
);

// File: tb/mailbox_irq_bench.sv
module mailbox_irq_bench;

  localparam int AW = 12;
  localparam int VW = 37;
  localparam int NV = 22;
  localparam logic [AW-1:0] FFE = 12'hFFE;
  localparam logic [AW-1:0] FFF = 12'hFFF;

  logic clk = 1'b0;
  logic rst;
  logic func_en;
  logic l_sel_n, l_we_n, l_oe_n, r_sel_n, r_we_n, r_oe_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mailbox_irq #(.ADDR_W(AW)) u_mailbox_irq (
    .clk(clk), .rst(rst), .func_en(func_en),
    .l_sel_n(l_sel_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .r_sel_n(r_sel_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  // Active-high arguments; pins are stored active low.
  // Layout: req[36:33] en[32] left{sel,we,oe}[31:29] laddr[28:17]
  //         right{sel,we,oe}[16:14] raddr[13:2] exp_l[1] exp_r[0]
  function automatic logic [VW-1:0] mk(input int req, input bit en,
      input bit ls, input bit lw, input bit lo, input logic [AW-1:0] la,
      input bit rs, input bit rw, input bit ro, input logic [AW-1:0] ra,
      input bit el, input bit er);
    logic [3:0] rq;
    rq = 4'(req);
    return {rq, en, ~ls, ~lw, ~lo, la, ~rs, ~rw, ~ro, ra, el, er};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    mk(10, 1, 0,0,0,12'h000, 0,0,0,12'h000, 1,1), // R10 idle
    mk( 2, 1, 0,0,0,12'h000, 1,1,0,FFE,     0,1), // R2 right writes left inbox
    mk(10, 1, 0,0,0,12'h000, 0,0,0,12'h000, 0,1), // R10 hold low
    mk(11, 1, 1,0,1,12'h123, 0,0,0,12'h000, 0,1), // R11 other read
    mk(11, 1, 1,0,1,FFF,     0,0,0,12'h000, 0,1), // R11 left reads peer inbox
    mk( 4, 1, 1,1,1,FFE,     0,0,0,12'h000, 1,1), // R4 read with strobe active
    mk( 3, 1, 1,1,0,FFF,     0,0,0,12'h000, 1,0), // R3 left writes right inbox
    mk( 6, 1, 0,0,0,12'h000, 0,1,0,FFE,     1,0), // R6 strobe without select
    mk( 6, 1, 0,0,0,12'h000, 1,0,1,FFE,     1,0), // R6 select+oe, no strobe
    mk( 6, 1, 0,0,0,12'h000, 1,1,1,FFE,     0,0), // R6 write with oe active
    mk( 7, 1, 0,0,0,12'h000, 1,1,0,FFF,     0,0), // R7 right writes own inbox
    mk( 7, 1, 1,1,0,12'hFFD, 0,0,0,12'h000, 0,0), // R7 other address
    mk( 5, 1, 0,0,0,12'h000, 1,0,1,FFF,     0,1), // R5 right acknowledges
    mk( 8, 1, 1,0,1,FFE,     1,1,0,FFE,     0,1), // R8 set beats clear, left
    mk( 4, 1, 1,0,1,FFE,     0,0,0,12'h000, 1,1), // R4 left acknowledges
    mk( 8, 1, 1,1,0,FFF,     1,0,1,FFF,     1,0), // R8 set beats clear, right
    mk( 9, 0, 0,0,0,12'h000, 0,0,0,12'h000, 1,1), // R9 disable drops pending
    mk( 9, 0, 0,0,0,12'h000, 1,1,0,FFE,     1,1), // R9 write while off
    mk( 9, 0, 1,1,0,FFF,     0,0,0,12'h000, 1,1), // R9 write while off
    mk( 9, 1, 0,0,0,12'h000, 0,0,0,12'h000, 1,1), // R9 nothing latched
    mk( 2, 1, 1,1,0,FFF,     1,1,0,FFE,     0,0), // R2 R3 both at once
    mk(10, 1, 0,0,0,12'h000, 0,0,0,12'h000, 0,0)  // R10 both held
  };

  task automatic check(input string req, input string sig,
                       input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, sig, act, exp);
    end
  endtask

  task automatic idle();
    l_sel_n = 1'b1; l_we_n = 1'b1; l_oe_n = 1'b1; l_addr = '0;
    r_sel_n = 1'b1; r_we_n = 1'b1; r_oe_n = 1'b1; r_addr = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    func_en = 1'b1;
    idle();
    // R1: a mailbox write during reset must not set anything.
    r_sel_n = 1'b0; r_we_n = 1'b0; r_addr = FFE;
    repeat (3) @(negedge clk);
    check("R1", "l_irq_n in reset", l_irq_n, 1'b1);
    check("R1", "r_irq_n in reset", r_irq_n, 1'b1);
    idle();
    rst = 1'b0;
    @(negedge clk);
    check("R1", "l_irq_n after reset", l_irq_n, 1'b1);
    check("R1", "r_irq_n after reset", r_irq_n, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string tag;
      v = VEC[i];
      func_en = v[32];
      l_sel_n = v[31]; l_we_n = v[30]; l_oe_n = v[29]; l_addr = v[28:17];
      r_sel_n = v[16]; r_we_n = v[15]; r_oe_n = v[14]; r_addr = v[13:2];
      @(negedge clk);
      tag = $sformatf("R%0d vec%0d", v[36:33], i);
      check(tag, "l_irq_n", l_irq_n, v[1]);
      check(tag, "r_irq_n", r_irq_n, v[0]);
    end

    // R1: reset with both interrupts pending returns them high.
    idle();
    func_en = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R1", "l_irq_n mid-run reset", l_irq_n, 1'b1);
    check("R1", "r_irq_n mid-run reset", r_irq_n, 1'b1);
    rst = 1'b0;

    // R10: a long idle keeps a raised interrupt low.
    r_sel_n = 1'b0; r_we_n = 1'b0; r_addr = FFE;
    @(negedge clk);
    idle();
    repeat (20) @(negedge clk);
    check("R10", "l_irq_n after long idle", l_irq_n, 1'b0);
    check("R10", "r_irq_n after long idle", r_irq_n, 1'b1);

    // R11: right reading the left inbox does not clear the left flag.
    r_sel_n = 1'b0; r_oe_n = 1'b0; r_addr = FFE;
    @(negedge clk);
    idle();
    check("R11", "l_irq_n after peer read", l_irq_n, 1'b0);

    finish_run();
  end

endmodule